// File: doc/BRIEF.md
# USB Device State Tracker

This block follows the state of a USB peripheral through its life on the bus: powered, default, addressed and configured, plus a suspended variant of each. It takes single-cycle pulses from logic outside it. These are a bus-reset-handshake-finished pulse, a suspend-detected pulse and a resume-detected pulse. It also takes completion strobes for the SetAddress and SetConfiguration standard requests, and each strobe comes with the value that the request carried.

The current 3-bit state code is always visible. Any enabled transition sets a sticky transition flag, which software clears by writing one. A return from suspend sets a separate resume flag instead. Four enable bits decide which transition causes raise the transition flag. The state itself always moves, whatever the enables say. A registered interrupt line reports the OR of the two flags.

Top module: `usb_devstate_tracker`

## Requirements
- R1: After reset, dev_state_o is 000 (Powered) and trans_flag_o, resume_flag_o and irq_o are all 0.
- R2: A suspend pulse moves Powered 000, Default 001, Address 010 or Configured 011 to the suspended code 100, 101, 110 or 111 respectively. If cause_en_i[3] is set, it also sets the transition flag.
- R3: A resume pulse in a suspended code 1xx restores 0xx and sets the resume flag, leaving the transition flag alone. A resume pulse in an operating state does nothing.
- R4: A bus-reset-done pulse moves 000, 010 or 011 to Default 001, setting the transition flag if cause_en_i[0] is set. In 001 or in any suspended code it is ignored.
- R5: SetAddress completion with a nonzero value moves 001 to 010. With value 0 it moves 010 to 001. Either move sets the transition flag if cause_en_i[1] is set.
- R6: SetConfiguration completion with a nonzero value moves 010 to 011. With value 0 it moves 011 to 010. Either move sets the transition flag if cause_en_i[2] is set.
- R7: A cleared enable bit only stops the flag being set. The state change takes place anyway.
- R8: An event that is not valid in the current state changes neither the state nor either flag.
- R9: Both flags stay set until the matching clear input is pulsed. If a new setting event arrives in the same cycle as the clear, the flag stays set.
- R10: irq_o is a register holding the OR of the transition flag and the resume flag from the previous cycle.
- R11: When several events arrive in one cycle, only the first valid one in this order takes effect: bus reset, suspend, resume, SetAddress, SetConfiguration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset_done_i | input | 1 | Pulse: bus reset handshake finished |
| suspend_det_i | input | 1 | Pulse: suspend detected |
| resume_det_i | input | 1 | Pulse: resume detected |
| set_addr_done_i | input | 1 | Pulse: SetAddress completed |
| set_addr_val_i | input | ADDR_W | Address carried by SetAddress |
| set_cfg_done_i | input | 1 | Pulse: SetConfiguration completed |
| set_cfg_val_i | input | CFG_W | Configuration value carried by SetConfiguration |
| cause_en_i | input | 4 | Flag enables: [0] bus reset, [1] SetAddress, [2] SetConfiguration, [3] suspend |
| clr_trans_i | input | 1 | Write-one-to-clear pulse for the transition flag |
| clr_resume_i | input | 1 | Write-one-to-clear pulse for the resume flag |
| dev_state_o | output | 3 | Current state code |
| trans_flag_o | output | 1 | Sticky state-transition flag |
| resume_flag_o | output | 1 | Sticky resume flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- a suspend always lands on the suspended code that matches the state it left, and a resume restores that state;
- a bus reset from a valid state always lands in Default;
- the state holds when no event arrives;
- flags stay set until cleared, a clear with no new cause takes effect;
- the transition flag only rises when an enabled cause fired;
- the interrupt follows the flags one cycle later.

Other behaviour needs the bench's scenarios to show it: the full round trip through every state, request values of zero against nonzero, events that are invalid in the current state, the enables being off while the state still moves, the clear-versus-set collision, and the order in which simultaneous events win.

// File: rtl/usbds_pkg.sv
package usbds_pkg;

    localparam int STATE_W   = 3;
    localparam int NUM_CAUSE = 4;

    // Cause bit positions in the enable vector and the cause vector
    localparam int CZ_RESET = 0;
    localparam int CZ_ADDR  = 1;
    localparam int CZ_CFG   = 2;
    localparam int CZ_SUSP  = 3;

    // Operating state codes; bit 2 set marks the suspended twin of each
    localparam logic [STATE_W-1:0] ST_POWERED    = 3'b000;
    localparam logic [STATE_W-1:0] ST_DEFAULT    = 3'b001;
    localparam logic [STATE_W-1:0] ST_ADDRESS    = 3'b010;
    localparam logic [STATE_W-1:0] ST_CONFIGURED = 3'b011;

    typedef struct packed {
        logic [STATE_W-1:0] state;
    } fsm_reg_t;

    typedef struct packed {
        logic trans;
        logic resume;
        logic irq;
    } flag_reg_t;

endpackage

// File: rtl/usbds_state_fsm.sv
module usbds_state_fsm
    import usbds_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CFG_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_reset_i,
    input  logic                  susp_i,
    input  logic                  resume_i,
    input  logic                  set_addr_i,
    input  logic [ADDR_W-1:0]     addr_val_i,
    input  logic                  set_cfg_i,
    input  logic [CFG_W-1:0]      cfg_val_i,
    output logic [STATE_W-1:0]    state_o,
    output logic [NUM_CAUSE-1:0]  cause_o,
    output logic                  resume_hit_o
);

    fsm_reg_t r_d, r_q;

    logic suspended;
    logic reset_ok;
    logic [1:0] base;

    always_comb begin
        r_d          = r_q;
        cause_o      = '0;
        resume_hit_o = 1'b0;
        suspended    = r_q.state[2];
        base         = r_q.state[1:0];
        reset_ok     = !suspended && (r_q.state != ST_DEFAULT);

        // Priority: bus reset, suspend, resume, SetAddress, SetConfiguration
        if (bus_reset_i && reset_ok) begin
            r_d.state         = ST_DEFAULT;
            cause_o[CZ_RESET] = 1'b1;
        end else if (susp_i && !suspended) begin
            r_d.state        = {1'b1, base};
            cause_o[CZ_SUSP] = 1'b1;
        end else if (resume_i && suspended) begin
            r_d.state    = {1'b0, base};
            resume_hit_o = 1'b1;
        end else if (set_addr_i && r_q.state == ST_DEFAULT && addr_val_i != '0) begin
            r_d.state        = ST_ADDRESS;
            cause_o[CZ_ADDR] = 1'b1;
        end else if (set_addr_i && r_q.state == ST_ADDRESS && addr_val_i == '0) begin
            r_d.state        = ST_DEFAULT;
            cause_o[CZ_ADDR] = 1'b1;
        end else if (set_cfg_i && r_q.state == ST_ADDRESS && cfg_val_i != '0) begin
            r_d.state       = ST_CONFIGURED;
            cause_o[CZ_CFG] = 1'b1;
        end else if (set_cfg_i && r_q.state == ST_CONFIGURED && cfg_val_i == '0) begin
            r_d.state       = ST_ADDRESS;
            cause_o[CZ_CFG] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_POWERED};
        else        r_q <= r_d;
    end

    assign state_o = r_q.state;

    // R2
    susp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_i && !r_q.state[2] && !(bus_reset_i && r_q.state != ST_DEFAULT))
        |=> (r_q.state == {1'b1, $past(r_q.state[1:0])}));

    // R3
    resume_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_i && r_q.state[2] && !susp_i)
        |=> (r_q.state == {1'b0, $past(r_q.state[1:0])}));

    // R4
    bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_i && !r_q.state[2] && r_q.state != ST_DEFAULT)
        |=> (r_q.state == ST_DEFAULT));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_reset_i || susp_i || resume_i || set_addr_i || set_cfg_i)
        |=> $stable(r_q.state));

endmodule

// File: rtl/usbds_flags.sv
module usbds_flags
    import usbds_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CAUSE-1:0] cause_i,
    input  logic [NUM_CAUSE-1:0] en_i,
    input  logic                 resume_hit_i,
    input  logic                 clr_trans_i,
    input  logic                 clr_resume_i,
    output logic                 trans_o,
    output logic                 resume_o,
    output logic                 irq_o
);

    flag_reg_t f_d, f_q;
    logic      trans_set;

    always_comb begin
        trans_set = |(cause_i & en_i);
        f_d.trans  = trans_set    | (f_q.trans  & ~clr_trans_i);
        f_d.resume = resume_hit_i | (f_q.resume & ~clr_resume_i);
        f_d.irq    = f_q.trans | f_q.resume;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign trans_o  = f_q.trans;
    assign resume_o = f_q.resume;
    assign irq_o    = f_q.irq;

    // R9
    trans_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.trans && !clr_trans_i) |=> f_q.trans);

    // R9
    trans_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_trans_i && (cause_i & en_i) == '0) |=> !f_q.trans);

    // R7
    trans_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.trans) |-> $past((cause_i & en_i) != '0));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (f_q.irq == $past(f_q.trans || f_q.resume)));

endmodule

// File: rtl/usb_devstate_tracker.sv
module usb_devstate_tracker
    import usbds_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset_done_i,
    input  logic              suspend_det_i,
    input  logic              resume_det_i,
    input  logic              set_addr_done_i,
    input  logic [ADDR_W-1:0] set_addr_val_i,
    input  logic              set_cfg_done_i,
    input  logic [CFG_W-1:0]  set_cfg_val_i,
    input  logic [3:0]        cause_en_i,
    input  logic              clr_trans_i,
    input  logic              clr_resume_i,
    output logic [2:0]        dev_state_o,
    output logic              trans_flag_o,
    output logic              resume_flag_o,
    output logic              irq_o
);

    logic [NUM_CAUSE-1:0] cause;
    logic                 resume_hit;

    usbds_state_fsm #(
        .ADDR_W (ADDR_W),
        .CFG_W  (CFG_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_reset_i  (bus_reset_done_i),
        .susp_i       (suspend_det_i),
        .resume_i     (resume_det_i),
        .set_addr_i   (set_addr_done_i),
        .addr_val_i   (set_addr_val_i),
        .set_cfg_i    (set_cfg_done_i),
        .cfg_val_i    (set_cfg_val_i),
        .state_o      (dev_state_o),
        .cause_o      (cause),
        .resume_hit_o (resume_hit)
    );

    usbds_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .cause_i      (cause),
        .en_i         (cause_en_i),
        .resume_hit_i (resume_hit),
        .clr_trans_i  (clr_trans_i),
        .clr_resume_i (clr_resume_i),
        .trans_o      (trans_flag_o),
        .resume_o     (resume_flag_o),
        .irq_o        (irq_o)
    );

endmodule

// File: tb/tb_usb_devstate_tracker.sv
`timescale 1ns/1ps
module tb_usb_devstate_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_rst = 1'b0, b_sus = 1'b0, b_res = 1'b0;
    logic       b_sa = 1'b0, b_sc = 1'b0;
    logic [6:0] b_sav = '0;
    logic [7:0] b_scv = '0;
    logic [3:0] en = 4'hF;
    logic       b_ct = 1'b0, b_cr = 1'b0;
    logic [2:0] st;
    logic       tf, rf, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_devstate_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .bus_reset_done_i(b_rst), .suspend_det_i(b_sus), .resume_det_i(b_res),
        .set_addr_done_i(b_sa), .set_addr_val_i(b_sav),
        .set_cfg_done_i(b_sc), .set_cfg_val_i(b_scv),
        .cause_en_i(en), .clr_trans_i(b_ct), .clr_resume_i(b_cr),
        .dev_state_o(st), .trans_flag_o(tf), .resume_flag_o(rf), .irq_o(irq)
    );

    typedef struct {
        logic [2:0] st;
        logic       t, r, i;
        string      tag;
    } exp_t;

    exp_t q[$];

    // Bench model of the requirements
    logic [2:0] m_st = 3'b000;
    logic       m_t = 1'b0, m_r = 1'b0, m_i = 1'b0;

    task automatic step(input logic r_e, input logic s_e, input logic u_e,
                        input logic a_e, input logic [6:0] a_v,
                        input logic c_e, input logic [7:0] c_v,
                        input logic ct, input logic cr, input string tag);
        logic [2:0] ns;
        logic       tset, rset;
        exp_t       e;
        @(negedge clk);
        b_rst = r_e; b_sus = s_e; b_res = u_e;
        b_sa = a_e; b_sav = a_v; b_sc = c_e; b_scv = c_v;
        b_ct = ct; b_cr = cr;
        ns = m_st; tset = 1'b0; rset = 1'b0;
        if (r_e && (m_st == 3'b000 || m_st == 3'b010 || m_st == 3'b011)) begin
            ns = 3'b001; tset = en[0];
        end else if (s_e && !m_st[2]) begin
            ns = {1'b1, m_st[1:0]}; tset = en[3];
        end else if (u_e && m_st[2]) begin
            ns = {1'b0, m_st[1:0]}; rset = 1'b1;
        end else if (a_e && m_st == 3'b001 && a_v != 0) begin
            ns = 3'b010; tset = en[1];
        end else if (a_e && m_st == 3'b010 && a_v == 0) begin
            ns = 3'b001; tset = en[1];
        end else if (c_e && m_st == 3'b010 && c_v != 0) begin
            ns = 3'b011; tset = en[2];
        end else if (c_e && m_st == 3'b011 && c_v == 0) begin
            ns = 3'b010; tset = en[2];
        end
        m_i  = m_t | m_r;
        m_t  = tset | (m_t & ~ct);
        m_r  = rset | (m_r & ~cr);
        m_st = ns;
        e.st = m_st; e.t = m_t; e.r = m_r; e.i = m_i; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 7'd0, 0, 8'd0, 0, 0, tag);
    endtask

    task automatic clr_all(input string tag);
        step(0, 0, 0, 0, 7'd0, 0, 8'd0, 1, 1, tag);
    endtask

    // Monitor: pops one expected item per clock, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (st !== e.st || tf !== e.t || rf !== e.r || irq !== e.i) begin
                failures++;
                $display("FAIL %s: actual st=%b t=%b r=%b irq=%b expected st=%b t=%b r=%b irq=%b",
                         e.tag, st, tf, rf, irq, e.st, e.t, e.r, e.i);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (st !== 3'b000 || tf !== 1'b0 || rf !== 1'b0 || irq !== 1'b0) begin
            failures++;
            $display("FAIL R1: actual st=%b t=%b r=%b irq=%b expected st=000 t=0 r=0 irq=0",
                     st, tf, rf, irq);
        end

        // R2 / R3 from Powered
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 powered suspend");
        idle("R10 irq after suspend");
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 resume to powered");
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 resume ignored when awake");
        clr_all("R9 clear both");
        idle("R10 irq drops");

        // R4 bus reset and invalid reset in Default
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 reset to default");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R4 reset ignored in default");
        step(0, 0, 0, 0, 0, 1, 8'd1, 0, 0, "R8 setcfg in default");
        step(0, 0, 0, 1, 7'd0, 0, 0, 0, 0, "R8 setaddr 0 in default");

        // R5 / R6 walk
        step(0, 0, 0, 1, 7'd5, 0, 0, 0, 0, "R5 setaddr nonzero");
        step(0, 0, 0, 1, 7'd9, 0, 0, 1, 0, "R8 setaddr nonzero in address");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 address suspend");
        step(1, 0, 0, 1, 7'd3, 0, 0, 1, 0, "R4 reset ignored when suspended");
        step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R3 resume to address");
        step(0, 0, 0, 0, 0, 1, 8'd2, 0, 1, "R6 setcfg nonzero");
        step(0, 1, 0, 0, 0, 0, 0, 1, 0, "R2 configured suspend");
        step(0, 0, 1, 0, 0, 0, 0, 1, 0, "R3 resume to configured");
        step(0, 0, 0, 0, 0, 1, 8'd7, 0, 1, "R8 setcfg nonzero in configured");
        step(0, 0, 0, 0, 0, 1, 8'd0, 0, 0, "R6 setcfg zero");
        step(0, 0, 0, 1, 7'd0, 0, 0, 1, 0, "R5 setaddr zero");
        clr_all("R9 clear after walk");

        // R7 enables off: state still moves, flag stays clear
        en = 4'h0;
        step(0, 0, 0, 1, 7'd3, 0, 0, 0, 0, "R7 setaddr no flag");
        step(0, 0, 0, 0, 0, 1, 8'd1, 0, 0, "R7 setcfg no flag");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 reset no flag");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 suspend no flag");
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 resume flag still set");
        clr_all("R9 clear resume");

        // R9 clear and set on the same cycle
        en = 4'b0010;
        step(0, 0, 0, 1, 7'd4, 0, 0, 0, 0, "R9 set by setaddr");
        step(0, 0, 0, 1, 7'd0, 0, 0, 1, 0, "R9 set wins over clear");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R9 clear alone");
        idle("R10 irq low");

        // R11 priority
        en = 4'hF;
        step(0, 0, 0, 1, 7'd6, 0, 0, 0, 0, "R5 back to address");
        step(1, 1, 0, 1, 7'd0, 0, 0, 1, 0, "R11 reset beats suspend");
        step(0, 1, 0, 1, 7'd2, 0, 0, 1, 0, "R11 suspend beats setaddr");
        step(1, 1, 1, 1, 7'd2, 1, 8'd1, 1, 0, "R11 resume when reset invalid");
        step(0, 0, 0, 1, 7'd8, 1, 8'd1, 1, 1, "R11 setaddr beats setcfg");
        step(0, 0, 0, 1, 7'd8, 1, 8'd1, 1, 0, "R11 setcfg after invalid setaddr");
        clr_all("R9 final clear");
        idle("R10 final irq");
        idle("R1 final idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule